// File: doc/BRIEF.md
# Watermark-Triggered QWORD Drain Controller

This block collects 64-bit words (QWORDs) from a capture path in a local buffer and pushes them out to a memory write interface. Draining does not begin on the first word. It starts when the fill level reaches a programmable watermark, and then it continues until the buffer is empty. The watermark is given as a small code `n` that stands for a level of `n*8+1` words.

Each transfer that the block starts is either a four-word burst or a single-word write. The choice depends on two things: whether more than four words are waiting, and whether the next target address sits on a 32-byte boundary. The buffer works in one of two depth modes. The planar mode uses 64 words. The linear mode uses 192 words and accepts a larger watermark code.

The output is a request/accept handshake that carries one word per beat, with the data, the byte address and a flag that marks beats belonging to a burst. Software loads a start address, and the block advances it by 8 bytes for every word it issues. The start address and the depth mode are changed only while the buffer and the output slot are empty.

Top module: `qword_drain_ctrl`

## Requirements
- R1: After a synchronous reset, `empty`=1, `full`=0, `ovf_flag`=0 and `req_valid`=0. The stored watermark code is 2, so the drain threshold is 17 words.
- R2: When `wm_wr` is high, the block stores `wm_code` as the watermark code. No request is raised while the buffer holds fewer than `code*8+1` words. When the fill level reaches that value, the first word is requested on the following cycle.
- R3: A code above the mode maximum is clamped to that maximum. The maximum is 7 (57 words) in planar mode (`lin_mode`=0) and 23 (185 words) in linear mode (`lin_mode`=1).
- R4: After draining has started, words keep being issued until the buffer is empty, even when the fill level falls below the threshold.
- R5: A burst starts when the buffer holds more than 4 words and bits [4:0] of the next address are zero. The burst is four consecutive beats with `req_burst`=1.
- R6: When the burst condition does not hold, a single-word transfer is issued with `req_burst`=0.
- R7: A pulse on `addr_ld` sets the address of the next word to `addr_in`. Each issued word carries the current address, and the address then advances by 8.
- R8: While `req_valid`=1 and `req_ready`=0, `req_data`, `req_addr` and `req_burst` hold their values.
- R9: Words leave in the order in which they were written.
- R10: `full` is raised at 64 words in planar mode and at 192 words in linear mode. The word held in the output slot is not counted.
- R11: A write while `full`=1 is dropped and never appears at the output. It sets `ovf_flag`, which stays set until reset.
- R12: No word is read from the buffer while it is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Capture-side write strobe |
| wr_data | input | 64 | Capture-side word |
| wm_wr | input | 1 | Load strobe for the watermark code |
| wm_code | input | 5 | Watermark code n (threshold n*8+1) |
| lin_mode | input | 1 | 1: 192-word linear mode, 0: 64-word planar mode |
| addr_ld | input | 1 | Load strobe for the next target address |
| addr_in | input | 32 | Byte address loaded by addr_ld |
| req_valid | output | 1 | Write beat offered |
| req_ready | input | 1 | Write beat accepted |
| req_burst | output | 1 | Beat belongs to a four-word burst |
| req_addr | output | 32 | Byte address of the beat |
| req_data | output | 64 | Data of the beat |
| full | output | 1 | Buffer at capacity for the mode |
| empty | output | 1 | Buffer holds no word |
| ovf_flag | output | 1 | Sticky: a write was dropped |

## Verification
The bench uses the default parameters: 192 words of physical storage, a 64-word planar limit, a 5-bit watermark code and four-beat bursts. With these values both clamp limits can be reached, and so can both capacity limits (64 and 192) and a 185-word threshold, all inside one short run. The table walk covers aligned and unaligned start addresses. As a result, drains contain pure burst runs, single words before an alignment point, and single-word tails once four or fewer words remain.

// File: rtl/qd_pkg.sv
`timescale 1ns/1ps
package qd_pkg;
  localparam int BURST_BEATS = 4;
  localparam int WORD_BYTES  = 8;
  localparam int ALIGN_BITS  = $clog2(BURST_BEATS * WORD_BYTES);
  localparam int WM_STEP     = 8;
endpackage

// File: rtl/qd_store.sv
`timescale 1ns/1ps
module qd_store #(
  parameter int DW    = 64,
  parameter int DEPTH = 192,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic             re,
  input  logic [PTR_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port doubles as the output data register
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/qd_watermark.sv
`timescale 1ns/1ps
module qd_watermark #(
  parameter int WM_W     = 5,
  parameter int CNT_W    = 8,
  parameter int WM_RESET = 2,
  parameter int MAX_LIN  = 23,
  parameter int MAX_PLN  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wm_wr,
  input  logic [WM_W-1:0]  wm_code,
  input  logic             lin_mode,
  output logic [CNT_W-1:0] thr
);
  import qd_pkg::*;
  logic [WM_W-1:0] code_q;
  logic [WM_W-1:0] lim;
  logic [WM_W-1:0] code_c;

  always_ff @(posedge clk) begin
    if (rst)        code_q <= WM_W'(WM_RESET);
    else if (wm_wr) code_q <= wm_code;
  end

  always_comb begin
    lim    = lin_mode ? WM_W'(MAX_LIN) : WM_W'(MAX_PLN);
    code_c = (code_q > lim) ? lim : code_q;
    thr    = CNT_W'(code_c) * CNT_W'(WM_STEP) + CNT_W'(1);
  end
endmodule

// File: rtl/qd_occupancy.sv
`timescale 1ns/1ps
module qd_occupancy #(
  parameter int DEPTH_LIN = 192,
  parameter int DEPTH_PLN = 64,
  parameter int PTR_W     = $clog2(DEPTH_LIN),
  parameter int CNT_W     = $clog2(DEPTH_LIN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lin_mode,
  input  logic             wr_en,
  input  logic             pop,
  output logic             push,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             full,
  output logic             empty,
  output logic             ovf_flag
);
  localparam logic [CNT_W-1:0] CAP_LIN = CNT_W'(DEPTH_LIN);
  localparam logic [CNT_W-1:0] CAP_PLN = CNT_W'(DEPTH_PLN);
  logic [CNT_W-1:0] cap;
  logic [PTR_W-1:0] last;

  always_comb begin
    cap     = lin_mode ? CAP_LIN : CAP_PLN;
    last    = PTR_W'(cap - CNT_W'(1));
    full    = (cnt == cap);
    empty   = (cnt == '0);
    push    = wr_en && !full;
    cnt_nxt = cnt + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (push) wptr <= (wptr == last) ? '0 : wptr + PTR_W'(1);
      if (pop)  rptr <= (rptr == last) ? '0 : rptr + PTR_W'(1);
      cnt <= cnt_nxt;
      if (wr_en && full) ovf_flag <= 1'b1;
    end
  end

  // R10
  cnt_cap_chk: assert property (@(posedge clk) disable iff (rst) cnt <= cap);
  // R12
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst) ovf_flag |=> ovf_flag);
endmodule

// File: rtl/qd_drain_sched.sv
`timescale 1ns/1ps
module qd_drain_sched #(
  parameter int AW    = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             empty,
  input  logic [CNT_W-1:0] thr,
  input  logic             addr_ld,
  input  logic [AW-1:0]    addr_in,
  input  logic             req_ready,
  output logic             pop,
  output logic             req_valid,
  output logic             req_burst,
  output logic [AW-1:0]    req_addr
);
  import qd_pkg::*;
  localparam int BL_W = $clog2(BURST_BEATS);

  logic            drain_on;
  logic [BL_W-1:0] beats_left;
  logic [AW-1:0]   nxt_addr;
  logic            go, slot_free, in_burst, aligned, start_burst;

  always_comb begin
    go          = drain_on || (cnt >= thr);
    slot_free   = !req_valid || req_ready;
    in_burst    = (beats_left != '0);
    pop         = slot_free && !empty && (in_burst || go);
    aligned     = (nxt_addr[ALIGN_BITS-1:0] == '0);
    start_burst = !in_burst && (cnt > CNT_W'(BURST_BEATS)) && aligned;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drain_on   <= 1'b0;
      beats_left <= '0;
      nxt_addr   <= '0;
      req_valid  <= 1'b0;
      req_burst  <= 1'b0;
      req_addr   <= '0;
    end else begin
      drain_on <= go && (cnt_nxt != '0);
      if (addr_ld)  nxt_addr <= addr_in;
      else if (pop) nxt_addr <= nxt_addr + AW'(WORD_BYTES);
      if (pop) begin
        req_valid <= 1'b1;
        req_addr  <= nxt_addr;
        req_burst <= in_burst || start_burst;
        if (in_burst)         beats_left <= beats_left - BL_W'(1);
        else if (start_burst) beats_left <= BL_W'(BURST_BEATS - 1);
      end else if (slot_free) begin
        req_valid <= 1'b0;
      end
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_burst)));
  // R5
  burst_run_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_burst && (req_addr[ALIGN_BITS-1:3] != '1)) |=> (req_valid && req_burst));
endmodule

// File: rtl/qword_drain_ctrl.sv
`timescale 1ns/1ps
module qword_drain_ctrl #(
  parameter int DW        = 64,
  parameter int AW        = 32,
  parameter int WM_W      = 5,
  parameter int DEPTH_LIN = 192,
  parameter int DEPTH_PLN = 64,
  parameter int MAX_LIN   = 23,
  parameter int MAX_PLN   = 7,
  parameter int WM_RESET  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wm_wr,
  input  logic [WM_W-1:0] wm_code,
  input  logic          lin_mode,
  input  logic          addr_ld,
  input  logic [AW-1:0] addr_in,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_burst,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  output logic          full,
  output logic          empty,
  output logic          ovf_flag
);
  localparam int PTR_W = $clog2(DEPTH_LIN);
  localparam int CNT_W = $clog2(DEPTH_LIN + 1);

  logic             push, pop;
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] cnt, cnt_nxt, thr;

  qd_watermark #(.WM_W(WM_W), .CNT_W(CNT_W), .WM_RESET(WM_RESET),
                 .MAX_LIN(MAX_LIN), .MAX_PLN(MAX_PLN)) u_wm (
    .clk(clk), .rst(rst), .wm_wr(wm_wr), .wm_code(wm_code),
    .lin_mode(lin_mode), .thr(thr));

  qd_occupancy #(.DEPTH_LIN(DEPTH_LIN), .DEPTH_PLN(DEPTH_PLN),
                 .PTR_W(PTR_W), .CNT_W(CNT_W)) u_occ (
    .clk(clk), .rst(rst), .lin_mode(lin_mode), .wr_en(wr_en), .pop(pop),
    .push(push), .wptr(wptr), .rptr(rptr), .cnt(cnt), .cnt_nxt(cnt_nxt),
    .full(full), .empty(empty), .ovf_flag(ovf_flag));

  qd_store #(.DW(DW), .DEPTH(DEPTH_LIN), .PTR_W(PTR_W)) u_store (
    .clk(clk), .we(push), .waddr(wptr), .wdata(wr_data),
    .re(pop), .raddr(rptr), .rdata(req_data));

  qd_drain_sched #(.AW(AW), .CNT_W(CNT_W)) u_sched (
    .clk(clk), .rst(rst), .cnt(cnt), .cnt_nxt(cnt_nxt), .empty(empty),
    .thr(thr), .addr_ld(addr_ld), .addr_in(addr_in), .req_ready(req_ready),
    .pop(pop), .req_valid(req_valid), .req_burst(req_burst), .req_addr(req_addr));
endmodule

// File: tb/tb_qword_drain_ctrl.sv
`timescale 1ns/1ps
module tb_qword_drain_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic        wm_wr = 1'b0;
  logic [4:0]  wm_code = '0;
  logic        lin_mode = 1'b0;
  logic        addr_ld = 1'b0;
  logic [31:0] addr_in = '0;
  logic        req_ready = 1'b1;
  logic        req_valid, req_burst, full, empty, ovf_flag;
  logic [31:0] req_addr;
  logic [63:0] req_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  qword_drain_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .wm_wr(wm_wr), .wm_code(wm_code), .lin_mode(lin_mode),
    .addr_ld(addr_ld), .addr_in(addr_in), .req_valid(req_valid),
    .req_ready(req_ready), .req_burst(req_burst), .req_addr(req_addr),
    .req_data(req_data), .full(full), .empty(empty), .ovf_flag(ovf_flag));

  // vector table: mode, code, keep-reset-code, start address, expected threshold
  localparam int NV = 7;
  localparam int V_LIN  [NV] = '{0, 0, 0, 0, 1, 1, 1};
  localparam int V_CODE [NV] = '{2, 0, 1, 9, 9, 31, 0};
  localparam int V_DEF  [NV] = '{1, 0, 0, 0, 0, 0, 0};
  localparam int V_ADDR [NV] = '{32'h1000, 32'h0, 32'h1008, 32'h2000, 32'h3018, 32'h4000, 32'h20};
  localparam int V_THR  [NV] = '{17, 1, 9, 57, 73, 185, 1};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wr_en = 1'b0; wm_wr = 1'b0; addr_ld = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic push(input logic [63:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_addr(input logic [31:0] a);
    addr_ld = 1'b1; addr_in = a;
    @(negedge clk);
    addr_ld = 1'b0;
  endtask

  task automatic set_wm(input logic [4:0] c);
    wm_wr = 1'b1; wm_code = c;
    @(negedge clk);
    wm_wr = 1'b0;
  endtask

  initial begin
    logic [63:0] base;
    int mc, ma, rem, idx, guard;
    bit exp_b;
    do_reset();
    // R1 reset state
    chk(empty == 1'b1, "R1 empty", 64'(empty), 64'd1);
    chk(full == 1'b0, "R1 full", 64'(full), 64'd0);
    chk(ovf_flag == 1'b0, "R1 ovf_flag", 64'(ovf_flag), 64'd0);
    chk(req_valid == 1'b0, "R1 req_valid", 64'(req_valid), 64'd0);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      lin_mode = V_LIN[v][0];
      req_ready = 1'b1;
      if (V_DEF[v] == 0) set_wm(V_CODE[v][4:0]);
      load_addr(V_ADDR[v]);
      base = {8'hC0 + 8'(v), 56'h0};
      for (int i = 0; i < V_THR[v] - 1; i++) push(base | 64'(i));
      @(negedge clk); @(negedge clk);
      // R2 / R3: nothing below the threshold
      chk(req_valid == 1'b0, "R2 R3 no request below threshold", 64'(req_valid), 64'd0);
      push(base | 64'(V_THR[v] - 1));
      @(negedge clk);
      // R2 / R3: request one cycle after the threshold is reached
      chk(req_valid == 1'b1, "R2 R3 request at threshold", 64'(req_valid), 64'd1);
      mc = V_THR[v]; ma = V_ADDR[v]; rem = 0; idx = 0; guard = 0;
      while (idx < V_THR[v] && guard < 400) begin
        if (req_valid) begin
          if (rem > 0) begin exp_b = 1'b1; rem--; end
          else if (mc > 4 && (ma % 32) == 0) begin exp_b = 1'b1; rem = 3; end
          else exp_b = 1'b0;
          chk(req_data == (base | 64'(idx)), "R9 data order", req_data, base | 64'(idx));
          chk(req_addr == 32'(ma), "R7 address", 64'(req_addr), 64'(ma));
          chk(req_burst == exp_b, exp_b ? "R5 burst flag" : "R6 single flag", 64'(req_burst), 64'(exp_b));
          ma += 8; mc--; idx++;
        end
        guard++;
        @(negedge clk);
      end
      // R4: drained all words, down to empty
      chk(idx == V_THR[v], "R4 beats drained", 64'(idx), 64'(V_THR[v]));
      chk(empty == 1'b1 && req_valid == 1'b0, "R4 empty after drain", {62'd0, empty, req_valid}, 64'd2);
    end

    // planar capacity, overflow drop, hold under backpressure
    do_reset();
    lin_mode = 1'b0; req_ready = 1'b0;
    set_wm(5'd7);
    load_addr(32'h8000);
    base = 64'hA500_0000_0000_0000;
    for (int i = 0; i < 64; i++) push(base | 64'(i));
    chk(full == 1'b0, "R10 planar not full at 63 stored", 64'(full), 64'd0);
    push(base | 64'd64);
    chk(full == 1'b1, "R10 planar full at 64", 64'(full), 64'd1);
    chk(ovf_flag == 1'b0, "R11 no overflow yet", 64'(ovf_flag), 64'd0);
    push(base | 64'd65);
    chk(ovf_flag == 1'b1, "R11 overflow set", 64'(ovf_flag), 64'd1);
    @(negedge clk); @(negedge clk);
    chk(ovf_flag == 1'b1, "R11 overflow sticky", 64'(ovf_flag), 64'd1);
    chk(req_valid == 1'b1 && req_data == base, "R8 held data", req_data, base);
    chk(req_addr == 32'h8000, "R8 held address", 64'(req_addr), 64'h8000);
    req_ready = 1'b1;
    idx = 0; guard = 0;
    while (guard < 200) begin
      if (req_valid) begin
        chk(req_data == (base | 64'(idx)), "R9 R11 order after overflow", req_data, base | 64'(idx));
        idx++;
      end
      guard++;
      @(negedge clk);
    end
    chk(idx == 65, "R11 dropped word absent", 64'(idx), 64'd65);

    // linear capacity
    do_reset();
    lin_mode = 1'b1; req_ready = 1'b0;
    set_wm(5'd23);
    for (int i = 0; i < 192; i++) push(64'(i));
    chk(full == 1'b0, "R10 linear not full at 191 stored", 64'(full), 64'd0);
    push(64'd192);
    chk(full == 1'b1, "R10 linear full at 192", 64'(full), 64'd1);
    chk(ovf_flag == 1'b0, "R11 linear no overflow", 64'(ovf_flag), 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule